// File: doc/BRIEF.md
# Carry-Masked Bit-Slice ALU

This block is a word-wide arithmetic/logic unit assembled from identical 4-bit slices. Each slice holds a single adder path. Every operation is produced by choosing the operand pair that enters the adder and then controlling that adder's internal carry chain. The chain can pass carries as normal, hold them at zero, or force them to one. With carries held at zero, the adder yields the exclusive-OR of its operands. With carries forced to one, every sum bit is inverted. The slices are joined by connecting each slice's carry-out to the next slice's carry-in. Any width that is a whole number of slices can be built this way.

A function select picks one of four operand pairs: A with B, A with the complement of B (subtraction), A with itself (doubling), or A with zero (pass or increment). A mode bit chooses between logical and arithmetic behaviour, and a force control drives the carry chain high. The wrapper derives four flags from the internal carries and the result: carry, auxiliary carry, overflow and zero. It then registers the result, the raw carry-out and the flags. All outputs appear on the clock edge after the inputs are sampled.

Top module: `carry_mask_alu`

## Requirements
- R1: While the synchronous active-high reset is asserted, every output reads 0.
- R2: In logical mode (logic_mode=1, force_ones=0) with fn_sel=0 (A,B), result equals A XOR B.
- R3: In logical mode with fn_sel=2 (A,A), result is 0 regardless of carry_in.
- R4: In arithmetic mode with fn_sel=0, {carry_out,result} equals A+B+carry_in, and flag_c equals carry_out.
- R5: In arithmetic mode with fn_sel=2, result equals A shifted left by one with carry_in entering bit 0, and carry_out equals A's MSB.
- R6: With fn_sel=1 in arithmetic mode, result equals A-B modulo 2^WIDTH. carry_in is ignored (the initial carry is forced to 1). flag_c is set exactly when A<B unsigned, i.e. it reports borrow as the inverse of carry_out.
- R7: With force_ones=1 (overriding logic_mode), result equals the bitwise inverse of (X XOR Y) for the selected operand pair. carry_out is 1, and flag_c, flag_ac and flag_v are 0.
- R8: In logical mode, carry_out, flag_c, flag_ac and flag_v all read 0.
- R9: In arithmetic mode, flag_ac equals the carry out of bit 3 of the adder, i.e. bit 4 of X[3:0]+Y[3:0]+initial carry.
- R10: In arithmetic mode, flag_v equals the XOR of the carries into and out of the MSB. This is set exactly when the two adder inputs share a sign that the result does not.
- R11: flag_z is 1 exactly when all WIDTH result bits are 0.
- R12: Carries ripple across slice boundaries, so 0x00FF+1 gives 0x0100 and 0xFFFF+0+carry_in gives 0 with carry_out 1.
- R13: With fn_sel=3 (A,0), arithmetic mode gives A+carry_in and logical mode gives A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| fn_sel | input | 2 | Operand pair: 0 A,B; 1 A,~B; 2 A,A; 3 A,0 |
| logic_mode | input | 1 | 1 masks every internal carry to zero |
| carry_in | input | 1 | Initial carry (unused for fn_sel=1) |
| force_ones | input | 1 | 1 drives every internal carry high |
| result | output | WIDTH | Registered result word |
| carry_out | output | 1 | Registered raw carry out of the top slice |
| flag_c | output | 1 | Carry, or borrow for subtraction |
| flag_ac | output | 1 | Carry out of bit 3 |
| flag_v | output | 1 | Signed overflow |
| flag_z | output | 1 | Result is all zeros |

## Verification
The same operand values are applied under logical, arithmetic and forced-carry control. This shows that masking or forcing the chain, rather than the operand choice, decides between XOR, sum and inverted XOR. Sums chosen to cross nibble and slice boundaries (0x00FF+1, 0xFFFF+carry) separate a correct cascade from one that drops carries between slices or at the auxiliary position. Signed-edge operands (0x7FFF+1, 0x8000-1) and subtractions with A above and below B separate overflow from carry and check the inverted borrow sense. A long pseudo-random sweep over all four operand pairs and three carry treatments is compared against an arithmetic model.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    FN_ADD  = 2'd0,
    FN_SUB  = 2'd1,
    FN_DBL  = 2'd2,
    FN_PASS = 2'd3
  } fn_e;
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  fn_e              fn,
  input  logic             cin,
  output logic [WIDTH-1:0] x,
  output logic [WIDTH-1:0] y,
  output logic             c0,
  output logic             is_sub
);
  always_comb begin
    x      = a;
    y      = b;
    c0     = cin;
    is_sub = 1'b0;
    unique case (fn)
      FN_ADD:  y = b;
      FN_SUB: begin
        y      = ~b;
        c0     = 1'b1;
        is_sub = 1'b1;
      end
      FN_DBL:  y = a;
      FN_PASS: y = '0;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice #(
  parameter int SW = 4
) (
  input  logic [SW-1:0] x,
  input  logic [SW-1:0] y,
  input  logic          c_in,
  input  logic          logic_mode,
  input  logic          force_ones,
  output logic [SW-1:0] sum,
  output logic          c_out
);
  logic [SW:0]   chain;
  logic [SW-1:0] prop;
  logic [SW-1:0] gen;

  assign prop = x ^ y;
  assign gen  = x & y;

  always_comb begin
    chain[0] = force_ones ? 1'b1 : (logic_mode ? 1'b0 : c_in);
    for (int i = 0; i < SW; i++) begin
      sum[i] = prop[i] ^ chain[i];
      if (force_ones)      chain[i+1] = 1'b1;
      else if (logic_mode) chain[i+1] = 1'b0;
      else                 chain[i+1] = gen[i] | (prop[i] & chain[i]);
    end
  end

  assign c_out = chain[SW];
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] res,
  input  logic             arith,
  input  logic             is_sub,
  input  logic             c_aux,
  input  logic             c_msb_in,
  input  logic             c_msb_out,
  output logic             f_c,
  output logic             f_ac,
  output logic             f_v,
  output logic             f_z
);
  always_comb begin
    f_c  = arith & (c_msb_out ^ is_sub);
    f_ac = arith & c_aux;
    f_v  = arith & (c_msb_in ^ c_msb_out);
    f_z  = (res == '0);
  end
endmodule

// File: rtl/carry_mask_alu.sv
module carry_mask_alu
  import alu_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int SLICE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       fn_sel,
  input  logic             logic_mode,
  input  logic             carry_in,
  input  logic             force_ones,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             flag_c,
  output logic             flag_ac,
  output logic             flag_v,
  output logic             flag_z
);
  localparam int NSLICE  = WIDTH / SLICE_W;
  localparam int AUX_BIT = 4;

  logic [WIDTH-1:0] x, y, sum;
  logic             c0, is_sub;
  logic [NSLICE:0]  link;

  alu_operand_sel #(.WIDTH(WIDTH)) u_sel (
    .a(op_a), .b(op_b), .fn(fn_e'(fn_sel)), .cin(carry_in),
    .x(x), .y(y), .c0(c0), .is_sub(is_sub)
  );

  assign link[0] = c0;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    alu_slice #(.SW(SLICE_W)) u_slice (
      .x(x[s*SLICE_W +: SLICE_W]),
      .y(y[s*SLICE_W +: SLICE_W]),
      .c_in(link[s]),
      .logic_mode(logic_mode),
      .force_ones(force_ones),
      .sum(sum[s*SLICE_W +: SLICE_W]),
      .c_out(link[s+1])
    );
  end

  // carries into a bit are recovered as x^y^sum
  logic c_aux, c_msb_in, arith;
  assign c_aux    = x[AUX_BIT] ^ y[AUX_BIT] ^ sum[AUX_BIT];
  assign c_msb_in = x[WIDTH-1] ^ y[WIDTH-1] ^ sum[WIDTH-1];
  assign arith    = ~logic_mode & ~force_ones;

  logic f_c, f_ac, f_v, f_z;
  alu_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .res(sum), .arith(arith), .is_sub(is_sub),
    .c_aux(c_aux), .c_msb_in(c_msb_in), .c_msb_out(link[NSLICE]),
    .f_c(f_c), .f_ac(f_ac), .f_v(f_v), .f_z(f_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      flag_c    <= 1'b0;
      flag_ac   <= 1'b0;
      flag_v    <= 1'b0;
      flag_z    <= 1'b0;
    end else begin
      result    <= sum;
      carry_out <= link[NSLICE];
      flag_c    <= f_c;
      flag_ac   <= f_ac;
      flag_v    <= f_v;
      flag_z    <= f_z;
    end
  end
endmodule

// File: rtl/carry_mask_alu_chk.sv
module carry_mask_alu_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [1:0]       fn_sel,
  input logic             logic_mode,
  input logic             carry_in,
  input logic             force_ones,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             flag_c,
  input logic             flag_ac,
  input logic             flag_v,
  input logic             flag_z
);
  p_xor_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(logic_mode) && !$past(force_ones) && $past(fn_sel) == 2'd0)
      |-> result == ($past(op_a) ^ $past(op_b)));

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(logic_mode) && !$past(force_ones) && $past(fn_sel) == 2'd2)
      |-> result == '0);

  p_add_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(logic_mode) && !$past(force_ones) && $past(fn_sel) == 2'd0)
      |-> {carry_out, result} ==
          ({1'b0, $past(op_a)} + {1'b0, $past(op_b)} + {{WIDTH{1'b0}}, $past(carry_in)}));

  p_force_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(force_ones))
      |-> carry_out && !flag_c && !flag_ac && !flag_v);

  p_no_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(logic_mode) && !$past(force_ones))
      |-> !carry_out && !flag_c && !flag_ac && !flag_v);

  p_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> flag_z == (result == '0));
endmodule

bind carry_mask_alu carry_mask_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/carry_mask_alu_tb.sv
module carry_mask_alu_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [1:0]   fn_sel = '0;
  logic         logic_mode = 1'b0, carry_in = 1'b0, force_ones = 1'b0;
  logic [W-1:0] result;
  logic         carry_out, flag_c, flag_ac, flag_v, flag_z;

  always #2 clk = ~clk;

  carry_mask_alu #(.WIDTH(W), .SLICE_W(4)) u_dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .fn_sel(fn_sel),
    .logic_mode(logic_mode), .carry_in(carry_in), .force_ones(force_ones),
    .result(result), .carry_out(carry_out), .flag_c(flag_c),
    .flag_ac(flag_ac), .flag_v(flag_v), .flag_z(flag_z)
  );

  typedef struct {
    logic [W-1:0] res;
    logic         co, c, ac, v, z;
    string        tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] fn,
                                 logic lg, logic ci, logic fo, string tag);
    exp_t e;
    logic [W-1:0] xv, yv;
    logic         cv;
    logic [W:0]   full;
    logic [4:0]   low;
    xv = a; cv = ci;
    case (fn)
      2'd0: yv = b;
      2'd1: begin yv = ~b; cv = 1'b1; end
      2'd2: yv = a;
      default: yv = '0;
    endcase
    e.tag = tag;
    if (fo) begin
      e.res = ~(xv ^ yv); e.co = 1'b1; e.c = 1'b0; e.ac = 1'b0; e.v = 1'b0;
    end else if (lg) begin
      e.res = xv ^ yv; e.co = 1'b0; e.c = 1'b0; e.ac = 1'b0; e.v = 1'b0;
    end else begin
      full  = {1'b0, xv} + {1'b0, yv} + {{W{1'b0}}, cv};
      low   = {1'b0, xv[3:0]} + {1'b0, yv[3:0]} + {4'd0, cv};
      e.res = full[W-1:0];
      e.co  = full[W];
      e.c   = (fn == 2'd1) ? ~full[W] : full[W];
      e.ac  = low[4];
      e.v   = (xv[W-1] == yv[W-1]) && (e.res[W-1] != xv[W-1]);
    end
    e.z = (e.res == '0);
    return e;
  endfunction

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] fn,
                       logic lg, logic ci, logic fo, string tag);
    @(negedge clk);
    op_a = a; op_b = b; fn_sel = fn; logic_mode = lg; carry_in = ci; force_ones = fo;
    q.push_back(model(a, b, fn, lg, ci, fo, tag));
  endtask

  // monitor: output registered at the posedge after the negedge drive
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (result !== e.res || carry_out !== e.co || flag_c !== e.c ||
          flag_ac !== e.ac || flag_v !== e.v || flag_z !== e.z) begin
        failures++;
        $display("FAIL %s: got res=%h co=%b c=%b ac=%b v=%b z=%b exp res=%h co=%b c=%b ac=%b v=%b z=%b",
                 e.tag, result, carry_out, flag_c, flag_ac, flag_v, flag_z,
                 e.res, e.co, e.c, e.ac, e.v, e.z);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    // R1: reset holds outputs at zero with busy inputs
    op_a = 16'hFFFF; op_b = 16'h0001; force_ones = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (result !== '0 || carry_out !== 1'b0 || flag_c !== 1'b0 || flag_ac !== 1'b0 ||
        flag_v !== 1'b0 || flag_z !== 1'b0) begin
      failures++;
      $display("FAIL R1: got res=%h co=%b c=%b ac=%b v=%b z=%b exp all zero",
               result, carry_out, flag_c, flag_ac, flag_v, flag_z);
    end
    rst = 1'b0; force_ones = 1'b0;

    drive(16'hA5C3, 16'h0FF0, 2'd0, 1, 1, 0, "R2");
    drive(16'h3C3C, 16'h3C3C, 2'd0, 1, 0, 0, "R11");
    drive(16'hFFFF, 16'hFFFF, 2'd1, 1, 0, 0, "R8");
    drive(16'hBEEF, 16'h0000, 2'd2, 1, 1, 0, "R3");
    drive(16'h1234, 16'h4321, 2'd0, 0, 0, 0, "R4");
    drive(16'h00FF, 16'h0001, 2'd0, 0, 0, 0, "R12");
    drive(16'h000F, 16'h0001, 2'd0, 0, 0, 0, "R9");
    drive(16'hFFFF, 16'h0000, 2'd0, 0, 1, 0, "R12");
    drive(16'h7FFF, 16'h0001, 2'd0, 0, 0, 0, "R10");
    drive(16'h8000, 16'h8000, 2'd0, 0, 0, 0, "R10");
    drive(16'h8421, 16'h0000, 2'd2, 0, 1, 0, "R5");
    drive(16'h4000, 16'h0000, 2'd2, 0, 0, 0, "R5");
    drive(16'h5000, 16'h1234, 2'd1, 0, 0, 0, "R6");
    drive(16'h0001, 16'h0002, 2'd1, 0, 1, 0, "R6");
    drive(16'h1234, 16'h1234, 2'd1, 0, 1, 0, "R6");
    drive(16'h8000, 16'h0001, 2'd1, 0, 0, 0, "R10");
    drive(16'hA5C3, 16'h0FF0, 2'd0, 0, 0, 1, "R7");
    drive(16'h1357, 16'h0000, 2'd2, 1, 0, 1, "R7");
    drive(16'h0F0F, 16'h00FF, 2'd1, 0, 1, 1, "R7");
    drive(16'h00FF, 16'h0000, 2'd3, 0, 1, 0, "R13");
    drive(16'hFFFF, 16'h0000, 2'd3, 0, 1, 0, "R13");
    drive(16'hC0DE, 16'h1111, 2'd3, 1, 1, 0, "R13");

    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      logic [15:0] a, b;
      logic [1:0]  f;
      logic        lg, fo, ci;
      string       tag;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = lfsr ^ 16'h5A5A;
      f = lfsr[1:0]; lg = lfsr[4]; fo = (lfsr[7:5] == 3'd0); ci = lfsr[9];
      if (fo)      tag = "R7";
      else if (lg) tag = "R8";
      else if (f == 2'd0) tag = "R4";
      else if (f == 2'd1) tag = "R6";
      else if (f == 2'd2) tag = "R5";
      else tag = "R13";
      drive(a, b, f, lg, ci, fo, tag);
    end

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule